// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block keeps two software-programmable memory address windows for a bridge between a primary and a secondary bus: one for non-prefetchable memory and one for prefetchable memory. Each window has a base and a limit, both at 1 MiB granularity. The base is inclusive and the limit is exclusive. A 32-bit register port with byte enables programs the two windows at byte offsets 20h (non-prefetchable) and 24h (prefetchable). Reads return the current register value in the same cycle.

Two address decoders run at the same time. A primary-side address is tested for a hit in either window and is forwarded downstream only while the memory-space enable is set. A secondary-side address is tested for a miss of both windows and is accepted upstream only while the bus-master enable is set. For each side the block also reports which window the address hit. All decode outputs are combinational from the addresses, the enables and the stored windows.

Top module: `mem_window_decode`

## Requirements
- R1: After a synchronous active-low reset, offset 20h reads 00000000h and offset 24h reads 00010001h.
- R2: A write to offset 20h with all byte enables set changes the register on the next clock edge. In this register, bits 31:20 are the limit field and bits 15:4 are the base field. Bits 19:16 and 3:0 always read 0.
- R3: In the register at offset 24h, bits 19:16 and bits 3:0 always read 1h and ignore writes. Bits 31:20 are the limit field and bits 15:4 are the base field.
- R4: Byte enable bit k (k = 0..3) selects data bits 8k+7:8k. A write changes only the writable bits of the selected bytes, and the other bytes keep their values.
- R5: An address whose bits 31:20 equal a window's base field hits that window. An address whose bits 31:20 are one below the base misses it.
- R6: An address whose bits 31:20 equal a window's limit field misses that window. An address whose bits 31:20 are the limit minus one hits it.
- R7: A window whose limit field is less than or equal to its base field never produces a hit.
- R8: fwd_down is 1 exactly when pri_addr hits at least one window and mem_space_en is 1.
- R9: accept_up is 1 exactly when sec_addr hits neither window and bus_master_en is 1.
- R10: The per-window hit outputs of each side are independent. An address inside two overlapping windows raises both hit outputs.
- R11: Reads of any offset other than 20h and 24h return 0. Writes to such offsets leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| mem_space_en | input | 1 | Permits downstream forwarding |
| bus_master_en | input | 1 | Permits upstream acceptance |
| pri_addr | input | 32 | Primary-side access address |
| sec_addr | input | 32 | Secondary-side access address |
| pri_hit_np | output | 1 | Primary address inside the non-prefetchable window |
| pri_hit_pf | output | 1 | Primary address inside the prefetchable window |
| fwd_down | output | 1 | Forward the primary access downstream |
| sec_hit_np | output | 1 | Secondary address inside the non-prefetchable window |
| sec_hit_pf | output | 1 | Secondary address inside the prefetchable window |
| accept_up | output | 1 | Accept the secondary access upstream |

## Verification
The only state in the block is the stored window fields. A corrupted base or limit bit therefore shows up in two places: on reg_rdata in the cycle that offset is read, and as a wrong hit, forward or accept decision for an address at the window's edge in the same cycle. For this reason the checks read each register back right after each write and probe addresses at exactly base-1, base, limit-1 and limit. The bench also probes empty windows and two overlapping windows.

// File: rtl/mwd_pkg.sv
// Package: shared constants and types for the memory window decoder.
// Assumes 32-bit registers with the limit field at the top and the base
// field starting at bit 4.
package mwd_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_WIN  = 2;
    localparam int NUM_SIDE = 2;
    localparam int BASE_LSB = 4;

    // Writable bits shared by both window registers.
    localparam logic [REG_W-1:0] FIELD_MASK = 32'hFFF0_FFF0;
    // Constant read-only bits of each register.
    localparam logic [REG_W-1:0] NP_FIXED = 32'h0000_0000;
    localparam logic [REG_W-1:0] PF_FIXED = 32'h0001_0001;

    typedef enum int {WIN_NP = 0, WIN_PF = 1} win_e;
    typedef enum int {SIDE_PRI = 0, SIDE_SEC = 1} side_e;
endpackage

// File: rtl/window_reg.sv
// Module: one window register with byte-enabled writes.
// Writable bits follow WMASK. Every other bit reads FIXED, which is also
// the reset value. Writes land on the edge after the strobe.
module window_reg #(
    parameter int               REG_W = 32,
    parameter logic [REG_W-1:0] WMASK = 32'hFFF0_FFF0,
    parameter logic [REG_W-1:0] FIXED = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [REG_W/8-1:0]   be,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     q
);
    localparam int NBYTE = REG_W / 8;

    logic [REG_W-1:0] q_r;

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        // Purpose: hold one byte, updating its writable bits when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r[8*b +: 8] <= FIXED[8*b +: 8];
            end else if (wr && be[b]) begin
                q_r[8*b +: 8] <= (wdata[8*b +: 8] & WMASK[8*b +: 8])
                               | FIXED[8*b +: 8];
            end
        end

        // R4: a byte that is not enabled keeps its value through the write.
        a_r4_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !be[b]) |=> $stable(q_r[8*b +: 8]));

        // R3: fixed bits keep their value when a write hits this byte.
        a_r3_fixed_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && be[b]) |=> ((q_r[8*b +: 8] & ~WMASK[8*b +: 8])
                               == FIXED[8*b +: 8]));
    end

    assign q = q_r;

    // R2: with no write strobe the register does not change.
    a_r2_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q_r));
endmodule

// File: rtl/window_match.sv
// Module: range test of one address against one window.
// Compares address bits [ADDR_W-1:GRAN_LSB] with an inclusive base and an
// exclusive limit. An empty window (limit <= base) never matches.
module window_match #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W-GRAN_LSB-1:0] base,
    input  logic [ADDR_W-GRAN_LSB-1:0] limit,
    output logic                       hit
);
    localparam int FIELD_W = ADDR_W - GRAN_LSB;

    logic [FIELD_W-1:0] page;
    logic               above_base;
    logic               below_limit;

    // Purpose: take the 1 MiB page number and compare it with both bounds.
    always_comb begin
        page        = addr[ADDR_W-1:GRAN_LSB];
        above_base  = (page >= base);
        below_limit = (page < limit);
        hit         = above_base && below_limit;
    end

    // R7: an empty window never reports a hit.
    a_r7_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (limit <= base) |-> !hit);

    // R5: the base page itself is inside a non-empty window.
    a_r5_base_inclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (page == base && limit > base) |-> hit);

    // R6: the limit page is always outside the window.
    a_r6_limit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (page == limit) |-> !hit);
endmodule

// File: rtl/mem_window_decode.sv
// Module: top level of the bridge memory window decoder.
// Holds the non-prefetchable and prefetchable windows and serves a same-cycle
// read / byte-enabled write port. It decodes a primary address (forward
// downstream on hit) and a secondary address (accept upstream on miss).
// Assumes ADDR_W - GRAN_LSB <= 12 so each field fits its register slot.
module mem_window_decode #(
    parameter int          ADDR_W    = 32,
    parameter int          GRAN_LSB  = 20,
    parameter int          OFF_W     = 8,
    parameter logic [7:0]  NP_OFFSET = 8'h20,
    parameter logic [7:0]  PF_OFFSET = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mem_space_en,
    input  logic              bus_master_en,
    input  logic [ADDR_W-1:0] pri_addr,
    input  logic [ADDR_W-1:0] sec_addr,
    output logic              pri_hit_np,
    output logic              pri_hit_pf,
    output logic              fwd_down,
    output logic              sec_hit_np,
    output logic              sec_hit_pf,
    output logic              accept_up
);
    import mwd_pkg::*;

    localparam int FIELD_W   = ADDR_W - GRAN_LSB;
    localparam int LIMIT_MSB = REG_W - 1;

    logic [REG_W-1:0]   win_q     [NUM_WIN];
    logic [FIELD_W-1:0] win_base  [NUM_WIN];
    logic [FIELD_W-1:0] win_limit [NUM_WIN];
    logic [NUM_WIN-1:0] win_wr;
    logic [ADDR_W-1:0]  side_addr [NUM_SIDE];
    logic [NUM_WIN-1:0] side_hit  [NUM_SIDE];

    assign side_addr[SIDE_PRI] = pri_addr;
    assign side_addr[SIDE_SEC] = sec_addr;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [OFF_W-1:0]  OFFSET = (w == WIN_NP) ? OFF_W'(NP_OFFSET)
                                                              : OFF_W'(PF_OFFSET);
        localparam logic [REG_W-1:0]  FIXED  = (w == WIN_NP) ? NP_FIXED : PF_FIXED;

        // Purpose: steer the write strobe to the register at this offset.
        always_comb win_wr[w] = reg_wr_en && (reg_addr == OFFSET);

        window_reg #(
            .REG_W (REG_W),
            .WMASK (FIELD_MASK),
            .FIXED (FIXED)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (win_wr[w]),
            .be    (reg_be),
            .wdata (reg_wdata),
            .q     (win_q[w])
        );

        // Purpose: extract the base and limit page fields from the register.
        always_comb begin
            win_base[w]  = win_q[w][BASE_LSB +: FIELD_W];
            win_limit[w] = win_q[w][LIMIT_MSB -: FIELD_W];
        end

        for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
            window_match #(
                .ADDR_W   (ADDR_W),
                .GRAN_LSB (GRAN_LSB)
            ) u_match (
                .clk   (clk),
                .rst_n (rst_n),
                .addr  (side_addr[s]),
                .base  (win_base[w]),
                .limit (win_limit[w]),
                .hit   (side_hit[s][w])
            );
        end
    end

    // Purpose: same-cycle read mux; unmapped offsets read zero.
    always_comb begin
        if (reg_addr == OFF_W'(NP_OFFSET)) begin
            reg_rdata = win_q[WIN_NP];
        end else if (reg_addr == OFF_W'(PF_OFFSET)) begin
            reg_rdata = win_q[WIN_PF];
        end else begin
            reg_rdata = '0;
        end
    end

    // Purpose: per-window hit flags and direction-gated routing decisions.
    always_comb begin
        pri_hit_np = side_hit[SIDE_PRI][WIN_NP];
        pri_hit_pf = side_hit[SIDE_PRI][WIN_PF];
        sec_hit_np = side_hit[SIDE_SEC][WIN_NP];
        sec_hit_pf = side_hit[SIDE_SEC][WIN_PF];
        fwd_down   = mem_space_en  && (|side_hit[SIDE_PRI]);
        accept_up  = bus_master_en && !(|side_hit[SIDE_SEC]);
    end

    // R8: downstream forwarding needs the memory-space enable and a hit.
    a_r8_fwd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_down |-> (mem_space_en && (pri_hit_np || pri_hit_pf)));

    // R9: upstream acceptance needs the bus-master enable and a double miss.
    a_r9_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
        accept_up |-> (bus_master_en && !sec_hit_np && !sec_hit_pf));

    // R10: the same address gives the same window flags on both sides.
    a_r10_sides_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_addr == sec_addr) |-> (pri_hit_np == sec_hit_np
                                    && pri_hit_pf == sec_hit_pf));

    // R11: a write to an unmapped offset leaves both registers unchanged.
    a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && win_wr == '0) |=> ($stable(win_q[WIN_NP])
                                         && $stable(win_q[WIN_PF])));
endmodule

// File: tb/mem_window_decode_tb_top.sv
// Scoreboard bench: driver tasks push expected vectors, a monitor compares.
module mem_window_decode_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_space_en = 1'b0;
    logic        bus_master_en = 1'b0;
    logic [31:0] pri_addr = '0;
    logic [31:0] sec_addr = '0;
    logic        pri_hit_np, pri_hit_pf, fwd_down;
    logic        sec_hit_np, sec_hit_pf, accept_up;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        logic [37:0] exp;
    } item_t;
    item_t sb_q[$];

    // Bench model of the registers, built from the requirements.
    logic [31:0] m_np = 32'h0;
    logic [31:0] m_pf = 32'h0001_0001;

    always #5 clk = ~clk;

    mem_window_decode dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_be        (reg_be),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .mem_space_en  (mem_space_en),
        .bus_master_en (bus_master_en),
        .pri_addr      (pri_addr),
        .sec_addr      (sec_addr),
        .pri_hit_np    (pri_hit_np),
        .pri_hit_pf    (pri_hit_pf),
        .fwd_down      (fwd_down),
        .sec_hit_np    (sec_hit_np),
        .sec_hit_pf    (sec_hit_pf),
        .accept_up     (accept_up)
    );

    function automatic logic in_win(logic [31:0] r, logic [31:0] a);
        return (a[31:20] >= r[15:4]) && (a[31:20] < r[31:20]);
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d,
                                          logic [3:0] be, logic [31:0] fixed);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++)
            if (be[b]) r[8*b +: 8] = (d[8*b +: 8] & 8'(32'hFFF0_FFF0 >> (8*b)))
                                    | fixed[8*b +: 8];
        return r;
    endfunction

    task automatic do_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        if (a == 8'h20) m_np = merge(m_np, d, be, 32'h0);
        if (a == 8'h24) m_pf = merge(m_pf, d, be, 32'h0001_0001);
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_be = 4'h0;
    endtask

    task automatic probe(string req, logic [7:0] ra, logic [31:0] pa,
                         logic [31:0] sa, logic mse, logic bme);
        item_t it;
        logic [31:0] rd;
        logic pn, pp, sn, sp;
        reg_addr = ra; pri_addr = pa; sec_addr = sa;
        mem_space_en = mse; bus_master_en = bme;
        rd = (ra == 8'h20) ? m_np : (ra == 8'h24) ? m_pf : 32'h0;
        pn = in_win(m_np, pa); pp = in_win(m_pf, pa);
        sn = in_win(m_np, sa); sp = in_win(m_pf, sa);
        it.req = req;
        it.exp = {rd, pn, pp, mse && (pn || pp), sn, sp, bme && !(sn || sp)};
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    // Monitor: pop one expected item per cycle and compare at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [37:0] act;
            it = sb_q.pop_front();
            act = {reg_rdata, pri_hit_np, pri_hit_pf, fwd_down,
                   sec_hit_np, sec_hit_pf, accept_up};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values; R7 empty windows at reset; R9 acceptance on miss.
        probe("R1", 8'h20, 32'h0000_0000, 32'h1234_5678, 1'b1, 1'b1);
        probe("R1", 8'h24, 32'h0010_0000, 32'h0, 1'b1, 1'b1);
        // R2 full write, reserved bits read zero.
        do_write(8'h20, 32'hFFFF_FFFF, 4'hF);
        probe("R2", 8'h20, 32'hFFF0_0000, 32'h0, 1'b1, 1'b1);
        // R3 fixed indicator bits.
        do_write(8'h24, 32'hFFFF_FFFF, 4'hF);
        probe("R3", 8'h24, 32'h0, 32'h0, 1'b1, 1'b1);
        do_write(8'h24, 32'h0000_0000, 4'hF);
        probe("R3", 8'h24, 32'h0, 32'h0, 1'b1, 1'b1);
        // NP window pages 010h..1FFh.
        do_write(8'h20, 32'h2000_0100, 4'hF);
        probe("R2", 8'h20, 32'h0100_0000, 32'h0100_0000, 1'b1, 1'b1);
        probe("R5", 8'h20, 32'h00FF_FFFF, 32'h00FF_FFFF, 1'b1, 1'b1);
        probe("R6", 8'h20, 32'h1FFF_FFFF, 32'h2000_0000, 1'b1, 1'b1);
        probe("R6", 8'h20, 32'h2000_0000, 32'h1FF0_0000, 1'b1, 1'b1);
        probe("R8", 8'h20, 32'h0500_0000, 32'h0, 1'b0, 1'b1);
        // PF window pages 180h..2FFh overlaps NP.
        do_write(8'h24, 32'h3000_1800, 4'hF);
        probe("R10", 8'h24, 32'h1900_0000, 32'h1900_0000, 1'b1, 1'b1);
        probe("R9", 8'h24, 32'h0000_0000, 32'h2500_0000, 1'b1, 1'b1);
        probe("R9", 8'h24, 32'h2500_0000, 32'h4000_0000, 1'b1, 1'b1);
        probe("R9", 8'h24, 32'h2500_0000, 32'h4000_0000, 1'b1, 1'b0);
        probe("R8", 8'h24, 32'h2FFF_0000, 32'h3000_0000, 1'b1, 1'b1);
        // R4 partial writes.
        do_write(8'h20, 32'hABCD_1234, 4'b0100);
        probe("R4", 8'h20, 32'h20B0_0000, 32'h20C0_0000, 1'b1, 1'b1);
        do_write(8'h20, 32'h0000_0055, 4'b0001);
        probe("R4", 8'h20, 32'h0140_0000, 32'h0150_0000, 1'b1, 1'b1);
        do_write(8'h24, 32'hFFFF_FFFF, 4'b1000);
        probe("R4", 8'h24, 32'hFF00_0000, 32'h0, 1'b1, 1'b1);
        // R7 empty windows: limit equal to base, then limit below base.
        do_write(8'h20, 32'h0500_0500, 4'hF);
        probe("R7", 8'h20, 32'h0500_0000, 32'h0500_0000, 1'b1, 1'b1);
        do_write(8'h20, 32'h0400_0500, 4'hF);
        probe("R7", 8'h20, 32'h0480_0000, 32'h0450_0000, 1'b1, 1'b1);
        // R11 unmapped offset.
        do_write(8'h28, 32'hFFFF_FFFF, 4'hF);
        probe("R11", 8'h28, 32'h0, 32'h0, 1'b1, 1'b1);
        probe("R11", 8'h20, 32'h0, 32'h0, 1'b1, 1'b1);
        probe("R11", 8'h24, 32'h0, 32'h0, 1'b1, 1'b1);
        @(posedge clk); #1;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule